// File: doc/BRIEF.md
# E1 Maintenance Timer Status Generator

This block produces the periodic timing flags that an E1 (2048 kbit/s, 32-slot) receive framer uses for performance monitoring and for CRC-4 multiframe alignment. It runs on the system clock. All of its timing advances on a single-cycle frame strobe that arrives once per 125 µs frame (8 kHz). The results come out as one registered 8-bit status word.

The word mixes three kinds of bit:

- **Free-running toggles.** Two bits toggle at half-second and one-second rates. They are kept in phase with each other.
- **Interval markers.** Two markers rise 64 frames (8 ms) before each one-second boundary and fall exactly on it. Their falling edge marks the start of the interval in which CRC errors and E-bit errors are accumulated.
- **Alignment-timer toggles.** Two one-shot timers (8 ms and 400 ms) toggle their bit once when they expire after a restart pulse.

One further bit reports alignment. While CRC-4 multiframe alignment is missing, it toggles every 16 frames. Once alignment is held, it follows the received multiframe: it goes high on each multiframe-start strobe and low eight frames later.

Top module: `e1_maint_timers`

## Requirements
- R1: A synchronous active-high `rst` clears all counters, leaves both alignment timers idle, and drives `status` to 8'h00.
- R2: `status[7]` toggles on every 4000th frame strobe after reset (every 0.5 s).
- R3: `status[6]` toggles on every 8000th frame strobe after reset (every 1 s). Each of its toggles falls on the same strobe as every second toggle of `status[7]`.
- R4: `status[5]` (CRC interval marker) is 1 for frame counts 7936 to 7999 within each 8000-frame second, and 0 otherwise. It falls on the strobe that starts a new second.
- R5: `status[4]` (E-bit interval marker) has the same timing as `status[5]`.
- R6: After a `restart_8ms` pulse, `status[2]` toggles on the 64th following frame strobe, and then not again until the next restart. A new restart pulse sets the count back to zero. Restart takes priority over a strobe in the same cycle.
- R7: After a `restart_400ms` pulse, `status[3]` toggles on the 3200th following frame strobe, and then not again until the next restart.
- R8: While `mf_aligned` is 0, `status[1]` toggles on every 16th frame strobe, and `mf_start` has no effect on it.
- R9: While `mf_aligned` is 1, `mf_start` sets `status[1]` to 1 in the next cycle. `status[1]` returns to 0 on the 8th frame strobe after that, and it does not toggle freely.
- R10: `status[0]` always reads 0.
- R11: In cycles without a frame strobe, no timing state advances. All timing bits hold; only the restart and multiframe-start inputs act.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-cycle strobe per 125 µs frame |
| mf_aligned | input | 1 | CRC-4 multiframe alignment held |
| mf_start | input | 1 | One-cycle strobe at the received multiframe start |
| restart_8ms | input | 1 | Restarts the 8 ms alignment timer |
| restart_400ms | input | 1 | Restarts the 400 ms alignment timer |
| status | output | 8 | {half-s, 1-s, CRC mark, E-bit mark, 400 ms, 8 ms, align, 0} |

## Verification
Every status bit is registered. Each result is therefore due in the cycle after the clock edge that samples the strobe, restart or multiframe-start that causes it, with no further pipeline delay. The interval markers are decoded from the registered second counter, so they land in the same cycle as the toggles. The bench changes inputs on the falling edge and holds the frame strobe high for exactly the number of rising edges the expected count requires. It then samples on the next falling edge, half a cycle after the edge that made the change. One frame short of each boundary it checks that the bit has not yet moved, and at the boundary itself it checks that the bit has moved.

// File: rtl/e1_maint_timers.sv
module e1_maint_timers #(
  parameter int HALF_SEC_FRAMES = 4000,
  parameter int MARK_FRAMES     = 64,
  parameter int T8_FRAMES       = 64,
  parameter int T400_FRAMES     = 3200,
  parameter int ALIGN_FRAMES    = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_tick,
  input  logic       mf_aligned,
  input  logic       mf_start,
  input  logic       restart_8ms,
  input  logic       restart_400ms,
  output logic [7:0] status
);

  localparam int SEC_FRAMES = 2 * HALF_SEC_FRAMES;
  localparam int SW  = $clog2(SEC_FRAMES);
  localparam int T8W = $clog2(T8_FRAMES);
  localparam int T4W = $clog2(T400_FRAMES);
  localparam int AW  = $clog2(ALIGN_FRAMES);

  localparam logic [SW-1:0]  SEC_LAST   = SW'(SEC_FRAMES - 1);
  localparam logic [SW-1:0]  HALF_LAST  = SW'(HALF_SEC_FRAMES - 1);
  localparam logic [SW-1:0]  MARK_START = SW'(SEC_FRAMES - MARK_FRAMES);
  localparam logic [T8W-1:0] T8_LAST    = T8W'(T8_FRAMES - 1);
  localparam logic [T4W-1:0] T4_LAST    = T4W'(T400_FRAMES - 1);
  localparam logic [AW-1:0]  AL_LAST    = AW'(ALIGN_FRAMES - 1);
  localparam logic [AW-1:0]  AL_MID     = AW'(ALIGN_FRAMES / 2 - 1);

  // Second counter and the free-running bits
  logic [SW-1:0] sec_cnt;
  logic          half_q, one_q;
  logic          at_half, at_end, acc_mark;

  assign at_half  = (sec_cnt == HALF_LAST);
  assign at_end   = (sec_cnt == SEC_LAST);
  assign acc_mark = (sec_cnt >= MARK_START);

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_cnt <= '0;
      half_q  <= 1'b0;
      one_q   <= 1'b0;
    end else if (frame_tick) begin
      sec_cnt <= at_end ? '0 : sec_cnt + 1'b1;
      if (at_half || at_end) half_q <= ~half_q;
      if (at_end)            one_q  <= ~one_q;
    end
  end

  // 8 ms one-shot alignment timer
  logic [T8W-1:0] t8_cnt;
  logic           t8_run, t8_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      t8_cnt <= '0;
      t8_run <= 1'b0;
      t8_q   <= 1'b0;
    end else if (restart_8ms) begin
      t8_cnt <= '0;
      t8_run <= 1'b1;
    end else if (frame_tick && t8_run) begin
      if (t8_cnt == T8_LAST) begin
        t8_run <= 1'b0;
        t8_q   <= ~t8_q;
      end else begin
        t8_cnt <= t8_cnt + 1'b1;
      end
    end
  end

  // 400 ms one-shot alignment timer
  logic [T4W-1:0] t4_cnt;
  logic           t4_run, t4_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      t4_cnt <= '0;
      t4_run <= 1'b0;
      t4_q   <= 1'b0;
    end else if (restart_400ms) begin
      t4_cnt <= '0;
      t4_run <= 1'b1;
    end else if (frame_tick && t4_run) begin
      if (t4_cnt == T4_LAST) begin
        t4_run <= 1'b0;
        t4_q   <= ~t4_q;
      end else begin
        t4_cnt <= t4_cnt + 1'b1;
      end
    end
  end

  // Alignment bit: free 2 ms toggle, or multiframe tracking
  logic [AW-1:0] al_cnt;
  logic          al_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      al_cnt <= '0;
      al_q   <= 1'b0;
    end else if (mf_aligned && mf_start) begin
      al_cnt <= '0;
      al_q   <= 1'b1;
    end else if (frame_tick) begin
      al_cnt <= (al_cnt == AL_LAST) ? '0 : al_cnt + 1'b1;
      if (mf_aligned) begin
        if (al_cnt == AL_MID) al_q <= 1'b0;
      end else if (al_cnt == AL_LAST) begin
        al_q <= ~al_q;
      end
    end
  end

  assign status = {half_q, one_q, acc_mark, acc_mark, t4_q, t8_q, al_q, 1'b0};

  // R3
  sec_in_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (one_q != $past(one_q)) |-> (half_q != $past(half_q)));

  // R4
  mark_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(acc_mark) |-> (sec_cnt == '0));

  // R6
  t8_oneshot_chk: assert property (@(posedge clk) disable iff (rst)
    (t8_q != $past(t8_q)) |-> ($past(t8_run) && !t8_run));

  // R7
  t4_oneshot_chk: assert property (@(posedge clk) disable iff (rst)
    (t4_q != $past(t4_q)) |-> ($past(t4_run) && !t4_run));

  // R11
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_tick |=> ($stable(half_q) && $stable(one_q) && $stable(sec_cnt)));

  // R8
  unaligned_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!mf_aligned && !frame_tick) |=> $stable(al_q));

  // R9
  mf_start_set_chk: assert property (@(posedge clk) disable iff (rst)
    (mf_aligned && mf_start) |=> al_q);

endmodule

// File: tb/e1_maint_timers_tb.sv
module e1_maint_timers_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int VEC_N = 10;

  // Ticks to add, then expected status (alignment free-running, timers idle)
  // R2 R3 R4 R5 R8 R10 are covered by this walk from reset.
  localparam int VEC_DELTA [VEC_N] = '{1, 15, 16, 3967, 1, 3935, 1, 63, 1, 4000};
  localparam logic [7:0] VEC_EXP [VEC_N] =
    '{8'h00, 8'h02, 8'h00, 8'h02, 8'h80, 8'h82, 8'hB0, 8'hB2, 8'h40, 8'hC0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_tick = 1'b0, mf_aligned = 1'b0, mf_start = 1'b0;
  logic restart_8ms = 1'b0, restart_400ms = 1'b0;
  logic [7:0] status;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  e1_maint_timers dut_i (
    .clk(clk), .rst(rst), .frame_tick(frame_tick), .mf_aligned(mf_aligned),
    .mf_start(mf_start), .restart_8ms(restart_8ms), .restart_400ms(restart_400ms),
    .status(status));

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      frame_tick = 1'b1;
      repeat (n) @(negedge clk);
      frame_tick = 1'b0;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    frame_tick = 1'b0; mf_start = 1'b0; restart_8ms = 1'b0; restart_400ms = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    check("R1", status, 8'h00);

    for (int i = 0; i < VEC_N; i++) begin
      ticks(VEC_DELTA[i]);
      check("R2/R3/R4/R5/R8/R10 vector", status, VEC_EXP[i]);
    end

    // R11: no strobe, nothing moves
    repeat (50) @(negedge clk);
    check("R11", status, 8'hC0);

    // R1 reset clears mid-run state
    do_reset();
    check("R1 re-reset", status, 8'h00);

    // R6: 8 ms timer one-shot
    restart_8ms = 1'b1; @(negedge clk); restart_8ms = 1'b0;
    ticks(63);
    check("R6 before expiry", status & 8'h04, 8'h00);
    ticks(1);
    check("R6 expiry", status & 8'h04, 8'h04);
    ticks(64);
    check("R6 stays after expiry", status & 8'h04, 8'h04);
    // R6 restart clears the count; restart beats a strobe in the same cycle
    restart_8ms = 1'b1; @(negedge clk); restart_8ms = 1'b0;
    ticks(40);
    frame_tick = 1'b1; restart_8ms = 1'b1; @(negedge clk);
    restart_8ms = 1'b0; frame_tick = 1'b0;
    ticks(63);
    check("R6 restart mid-count", status & 8'h04, 8'h04);
    ticks(1);
    check("R6 restarted expiry", status & 8'h04, 8'h00);

    // R7: 400 ms timer one-shot
    do_reset();
    restart_400ms = 1'b1; @(negedge clk); restart_400ms = 1'b0;
    ticks(3199);
    check("R7 before expiry", status & 8'h08, 8'h00);
    ticks(1);
    check("R7 expiry", status & 8'h08, 8'h08);
    ticks(3200);
    check("R7 stays after expiry", status & 8'h08, 8'h08);

    // R8: mf_start ignored while unaligned
    do_reset();
    ticks(5);
    mf_start = 1'b1; @(negedge clk); mf_start = 1'b0;
    check("R8 mf_start ignored", status & 8'h02, 8'h00);
    ticks(10);
    check("R8 15 frames", status & 8'h02, 8'h00);
    ticks(1);
    check("R8 16 frames", status & 8'h02, 8'h02);

    // R9: aligned multiframe tracking
    do_reset();
    mf_aligned = 1'b1;
    ticks(20);
    check("R9 no free toggle", status & 8'h02, 8'h00);
    mf_start = 1'b1; @(negedge clk); mf_start = 1'b0;
    check("R9 set on mf_start", status & 8'h02, 8'h02);
    ticks(7);
    check("R9 before midpoint", status & 8'h02, 8'h02);
    ticks(1);
    check("R9 midpoint clear", status & 8'h02, 8'h00);
    ticks(30);
    check("R9 held low", status & 8'h02, 8'h00);
    check("R10 bit0", status & 8'h01, 8'h00);
    mf_aligned = 1'b0;

    finish_run();
  end
endmodule